// File: doc/BRIEF.md
# Sliding-Window Insertion Sorter

The block keeps the most recent N samples of a serial data stream in ascending order. Each time a sample is accepted, the block drops the sample that has been in the window longest and places the new sample at its sorted position. Both happen in one clock edge. The sorted window sits in a chain of identical cells. Each cell holds one value, an arrival age and a valid flag. Each cell picks its own next value from four local control terms: keep its value, copy from the lower neighbour, copy from the upper neighbour, or take the incoming sample.

Every slot is driven out in parallel with its own valid flag. Logic downstream can read the minimum, the maximum, any rank, or the whole set in the same cycle. Invalid slots are always at the top and count as larger than any value.

A small controller tracks whether the window is filling or full, and it allows eviction only once the window is full. Its states are ST_EMPTY (nothing stored), ST_FILL (between 1 and N-1 samples stored) and ST_FULL (N samples stored). It has three transitions:
- ST_EMPTY goes to ST_FILL on the first accepted sample.
- ST_FILL goes to ST_FULL on the accepted sample that brings the count to N.
- ST_FULL stays in ST_FULL.

Reset returns the controller to ST_EMPTY. N must be at least 2.

Top module: `fifo_insert_sorter`

## Requirements
- R1: While rst_n is low and right after its release, every bit of slot_valid is 0.
- R2: While fewer than N samples are held, each cycle with in_valid high adds exactly one valid slot, and no earlier sample is lost.
- R3: Once N samples are held, each cycle with in_valid high removes the sample that arrived earliest of those held and adds the new one. The valid slots then hold exactly the last N accepted samples, whatever their values.
- R4: Slot k is bits [k*W +: W] of slot_data, and its flag is slot_valid[k]. Valid slots occupy indices 0 up to the count minus 1. Their values do not decrease from slot 0 upward.
- R5: In a cycle with in_valid low, slot_data and slot_valid keep their values.
- R6: A sample accepted at a clock edge shows in the outputs right after that edge. This includes the value 0 and the all-ones value, and the all-ones value sorts below the empty slots.
- R7: Repeated equal values are held and evicted correctly. Each copy counts as a separate sample and leaves the window in its own arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | W | Incoming sample, unsigned |
| slot_data | output | N*W | All sorted slots, slot 0 in the low bits |
| slot_valid | output | N | Per-slot valid flag |

## Verification
The bench fills the window with descending values and with the values 0 and all-ones. A cell that confused an empty slot with a stored all-ones value would misplace those samples or drop them. Random streams, with the strobe sometimes off, check that the evicted sample is the oldest whether it sits at the bottom, the middle or the top of the order. A design that evicted by value, or shifted the wrong range of cells, would lose a recent sample and keep a stale one. Streams built only from two values that repeat test the duplicate case, where a broken age chain would leave extra copies of one value. A reset in the middle of a run followed by a refill confirms that the flags clear and that the controller counts the window again from empty.

// File: rtl/fsort_pkg.sv
package fsort_pkg;

    // Per-cell next-state choice
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_FROM_LO = 2'd1,
        OP_FROM_HI = 2'd2,
        OP_LOAD    = 2'd3
    } cell_op_e;

    // Window occupancy controller
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/fsort_ctrl.sv
module fsort_ctrl
    import fsort_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic evict_en
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_FILL = CW'(N - 1);

    fill_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) begin
                    state_d = ST_FILL;
                    cnt_d   = CW'(1);
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LAST_FILL) begin
                        state_d = ST_FULL;
                    end
                end
            end
            ST_FULL: begin
                state_d = ST_FULL;
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FULL:  evict_en = 1'b1;
            default:  evict_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsort_cell.sv
module fsort_cell
    import fsort_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3,
    parameter logic [AW-1:0] AGE_MAX = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [W-1:0]  din,
    input  logic          evict_en,
    input  logic          ebelow_in,
    output logic          ebelow_out,
    input  logic          gt_lo,
    input  logic          gt_hi,
    output logic          gt_out,
    input  logic [W-1:0]  lo_val,
    input  logic [AW-1:0] lo_age,
    input  logic          lo_vld,
    input  logic [W-1:0]  hi_val,
    input  logic [AW-1:0] hi_age,
    input  logic          hi_vld,
    output logic [W-1:0]  val,
    output logic [AW-1:0] age,
    output logic          vld
);

    logic [W-1:0]  val_q;
    logic [AW-1:0] age_q;
    logic          vld_q;
    logic          gt, ev, down_side;
    logic          f_lo, f_hi, f_ld;
    cell_op_e      op;

    // Empty slot acts as +infinity; equal stored values stay below the new one
    assign gt         = !vld_q || (val_q > din);
    assign ev         = evict_en && vld_q && (age_q == AGE_MAX);
    assign ebelow_out = ebelow_in | ev;
    assign gt_out     = gt;

    // Cells at or above the vacated slot close the gap downward
    assign down_side = ebelow_in || (ev && !gt);

    // Four parallel control terms
    assign f_hi = down_side && !gt_hi;
    assign f_ld = (down_side && gt_hi && !gt) || (!down_side && gt && !gt_lo);
    assign f_lo = !down_side && gt && gt_lo;

    always_comb begin
        if (f_ld)      op = OP_LOAD;
        else if (f_hi) op = OP_FROM_HI;
        else if (f_lo) op = OP_FROM_LO;
        else           op = OP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            age_q <= '0;
            vld_q <= 1'b0;
        end else if (upd) begin
            unique case (op)
                OP_LOAD: begin
                    val_q <= din;
                    age_q <= '0;
                    vld_q <= 1'b1;
                end
                OP_FROM_HI: begin
                    val_q <= hi_val;
                    age_q <= hi_age + AW'(1);
                    vld_q <= hi_vld;
                end
                OP_FROM_LO: begin
                    val_q <= lo_val;
                    age_q <= lo_age + AW'(1);
                    vld_q <= lo_vld;
                end
                OP_HOLD: begin
                    age_q <= age_q + AW'(1);
                end
                default: begin
                    vld_q <= vld_q;
                end
            endcase
        end
    end

    assign val = val_q;
    assign age = age_q;
    assign vld = vld_q;

endmodule

// File: rtl/fifo_insert_sorter.sv
module fifo_insert_sorter
    import fsort_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic [N*W-1:0] slot_data,
    output logic [N-1:0]   slot_valid
);

    localparam int AW = (N > 1) ? $clog2(N) : 1;
    localparam logic [AW-1:0] AGE_MAX = AW'(N - 1);

    logic          evict_en;
    // Padded neighbour arrays: index k+1 is cell k
    logic [W-1:0]  val_x [N+2];
    logic [AW-1:0] age_x [N+2];
    logic          vld_x [N+2];
    logic          gt_x  [N+2];
    logic          ebl   [N+1];

    assign val_x[0]   = '0;
    assign age_x[0]   = '0;
    assign vld_x[0]   = 1'b0;
    assign gt_x[0]    = 1'b0;
    assign val_x[N+1] = '0;
    assign age_x[N+1] = '0;
    assign vld_x[N+1] = 1'b0;
    assign gt_x[N+1]  = 1'b1;
    assign ebl[0]     = 1'b0;

    fsort_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .evict_en (evict_en)
    );

    for (genvar k = 0; k < N; k++) begin : g_cell
        fsort_cell #(.W(W), .AW(AW), .AGE_MAX(AGE_MAX)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd        (in_valid),
            .din        (in_data),
            .evict_en   (evict_en),
            .ebelow_in  (ebl[k]),
            .ebelow_out (ebl[k+1]),
            .gt_lo      (gt_x[k]),
            .gt_hi      (gt_x[k+2]),
            .gt_out     (gt_x[k+1]),
            .lo_val     (val_x[k]),
            .lo_age     (age_x[k]),
            .lo_vld     (vld_x[k]),
            .hi_val     (val_x[k+2]),
            .hi_age     (age_x[k+2]),
            .hi_vld     (vld_x[k+2]),
            .val        (val_x[k+1]),
            .age        (age_x[k+1]),
            .vld        (vld_x[k+1])
        );
        assign slot_data[k*W +: W] = val_x[k+1];
        assign slot_valid[k]       = vld_x[k+1];
    end

    logic unused_ok;
    assign unused_ok = ebl[N];

endmodule

// File: rtl/fsort_chk.sv
module fsort_chk #(
    parameter int N = 8,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   in_data,
    input logic [N*W-1:0] slot_data,
    input logic [N-1:0]   slot_valid
);

    logic [W-1:0] last_din;
    logic         hit;

    always_ff @(posedge clk) last_din <= in_data;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (slot_valid[k] && slot_data[k*W +: W] == last_din) hit = 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (slot_valid == '0));

    // R2
    fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(&slot_valid)) |=>
        ($countones(slot_valid) == $past($countones(slot_valid)) + 1));

    // R3
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&slot_valid)) |=> (&slot_valid));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(slot_data) && $stable(slot_valid)));

    // R6
    new_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> hit);

    for (genvar k = 0; k + 1 < N; k++) begin : g_ord
        // R4
        sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[k+1] |-> (slot_valid[k] &&
                (slot_data[k*W +: W] <= slot_data[(k+1)*W +: W])));
    end

endmodule

bind fifo_insert_sorter fsort_chk #(.N(N), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .slot_data  (slot_data),
    .slot_valid (slot_valid)
);

// File: tb/fifo_insert_sorter_test.sv
`timescale 1ns/1ps
module fifo_insert_sorter_test;

    localparam int N = 8;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_data = '0;
    logic [N*W-1:0] slot_data;
    logic [N-1:0]   slot_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0] hist [N];
    int hcnt = 0;

    always #2 clk = ~clk;

    fifo_insert_sorter #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .slot_data(slot_data), .slot_valid(slot_valid)
    );

    task automatic push_model(input logic [W-1:0] d);
        if (hcnt < N) begin
            hist[hcnt] = d;
            hcnt++;
        end else begin
            for (int i = 0; i < N - 1; i++) hist[i] = hist[i+1];
            hist[N-1] = d;
        end
    endtask

    task automatic compare(input string tag);
        logic [W-1:0] s [N];
        logic [W-1:0] t;
        logic [N-1:0] ev;
        for (int i = 0; i < N; i++) s[i] = hist[i];
        for (int i = 0; i < hcnt; i++)
            for (int j = 0; j + 1 < hcnt - i; j++)
                if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
        ev = '0;
        for (int i = 0; i < hcnt; i++) ev[i] = 1'b1;
        checks++;
        if (slot_valid !== ev) begin
            failures++;
            $display("FAIL %s R4 slot_valid actual=%b expected=%b", tag, slot_valid, ev);
        end
        for (int i = 0; i < hcnt; i++) begin
            checks++;
            if (slot_data[i*W +: W] !== s[i]) begin
                failures++;
                $display("FAIL %s slot %0d actual=%0d expected=%0d", tag, i,
                         slot_data[i*W +: W], s[i]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        if (v) push_model(d);
        compare(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        hcnt = 0;
        #1;
        checks++;
        if (slot_valid !== '0) begin
            failures++;
            $display("FAIL R1 in reset actual=%b expected=0", slot_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (slot_valid !== '0) begin
            failures++;
            $display("FAIL R1 after release actual=%b expected=0", slot_valid);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (R1 to R7 incomplete)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        do_reset();

        // R6: extremes while filling, descending order; R2 fill growth
        step(1'b1, 8'hFF, "R6");
        step(1'b1, 8'h00, "R6");
        for (int i = 0; i < N - 2; i++) step(1'b1, W'(200 - 20 * i), "R2");
        // R5: idle cycles leave everything untouched
        for (int i = 0; i < 4; i++) step(1'b0, 8'h55, "R5");
        // R3: oldest is max (FF), then min (00), then middle values
        for (int i = 0; i < N + 3; i++) step(1'b1, W'(17 * i + 3), "R3");

        // R3 / R5: random stream with gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, W'($urandom), "R3");
        end

        // R7: heavy duplicates
        for (int i = 0; i < 400; i++) begin
            step(1'b1, (($urandom % 2) != 0) ? 8'd5 : 8'd6, "R7");
        end
        for (int i = 0; i < N + 2; i++) step(1'b1, 8'd9, "R7");

        // R1: reset mid-run then refill with all-ones duplicates
        do_reset();
        for (int i = 0; i < N + 4; i++) step(1'b1, 8'hFF, "R6");
        step(1'b1, 8'h00, "R3");
        step(1'b0, 8'h00, "R5");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule